// File: doc/BRIEF.md
# Load/Store Abort Offset Decoder

After a data abort, a handler has to work out what address arithmetic the faulting instruction carried out. This block does that work in hardware for single-transfer instructions of a 32-bit RISC instruction set. It takes three inputs: the faulting instruction word, the register-file value of the instruction's index register and the saved carry flag. From these it rebuilds the offset magnitude, the direction in which that offset applies, and whether the base register is written back.

It also checks for base/index register combinations that make the access ill-defined. When it finds one, it reports an error code and no offset is usable. The block covers five transfer classes: swap, halfword/signed-byte, coprocessor, word/byte with an immediate offset, and word/byte with a shifted register offset. Any other instruction gets the "unexpected" code.

A one-cycle strobe starts a decode. The result appears on registered outputs exactly one clock later.

Top module: `abort_offset_decoder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after an `in_valid` strobe and low otherwise. When there is no strobe, `offset`, `up`, `wb` and `err` hold their previous values.
- R2: While `rst_n` is low, every output is zero.
- R3: The instruction class is taken from these bit patterns:
  - `instr[27:26]=01` is word/byte, with `instr[25]` selecting the register-offset form.
  - `instr[27:25]=000` with `instr[7]=1` and `instr[4]=1` is swap if `instr[6:5]=00`, and halfword otherwise.
  - `instr[27:25]=110` is coprocessor.
  - Anything else gets error code 1 (unexpected).
  - Error codes are 4 bits wide and 0 means no error.
- R4: For the halfword and word/byte classes, `wb` is `instr[21]` OR NOT `instr[24]`, so a post-indexed access always writes back. For swap and coprocessor, `wb` is `instr[21]` unchanged.
- R5: A swap needs `instr[24]=1` and `instr[21]=0`, otherwise it gets error 1. A swap with base register `instr[19:16]=15` gets error 2. A legal swap has offset 0.
- R6: A halfword transfer with `instr[22]=1` has offset `{instr[11:8], instr[3:0]}`. With `instr[22]=0`, its offset is `index_val`.
- R7: A coprocessor transfer has offset `instr[7:0]*4`.
- R8: An immediate word/byte transfer has offset `instr[11:0]`.
- R9: In the register-offset halfword and word forms, an index register of `instr[3:0]=15` gets error 3. This check takes priority over R10.
- R10: In the register-offset forms, if the index register equals the base register and `wb` (after R4) is 1, the error is 4 when `instr[24]=1` and 5 when `instr[24]=0`.
- R11: A register-offset word transfer with `instr[4]=1` gets error 1.
- R12: A register-offset word transfer shifts `index_val` by amount `instr[11:7]`. The shift type comes from `instr[6:5]`: 00 is logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R13: A shift amount of 0 has special meanings:
  - Logical right gives 0.
  - Arithmetic right fills every bit with `index_val[31]`.
  - Rotate right becomes a one-bit rotate through `carry_in` (carry enters bit 31).
  - Logical left passes `index_val` through unchanged.
- R14: For every class, `up` equals `instr[23]` of the decoded instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle decode strobe |
| instr | input | 32 | Faulting instruction word |
| index_val | input | 32 | Value of the index register named by instr[3:0] |
| carry_in | input | 1 | Saved carry flag, used by the rotate-through-carry shift |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| offset | output | 32 | Offset magnitude; don't-care when err is non-zero |
| up | output | 1 | 1 when the offset is added, 0 when it is subtracted |
| wb | output | 1 | Effective base writeback flag |
| err | output | 4 | Error code, 0 for none |

## Verification
Each decode lands in a single output register, so a wrong next value shows up in the cycle right after the strobe. The symptom is a wrong offset, a missed writeback forcing or a wrong error code. The bench looks for it there, and looks again one idle cycle later to confirm the value is held. The shift-by-zero cases use operands that tell each special meaning apart from a naive shift: an all-ones value for logical right, both sign polarities for arithmetic right, and both carry values for the one-bit rotate. The priority of the error checks is tested with instructions that trip more than one condition.

// File: rtl/abort_dec_pkg.sv
package abort_dec_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 4;
    localparam int ERR_W  = 4;
    localparam int AMT_W  = $clog2(WORD_W);

    // Bit positions the decode depends on
    localparam int BIT_PRE   = 24;
    localparam int BIT_UP    = 23;
    localparam int BIT_HIMM  = 22;
    localparam int BIT_WB    = 21;
    localparam int BIT_REGOF = 25;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE       = 4'd0,
        ERR_UNEXPECTED = 4'd1,
        ERR_BASE_PC    = 4'd2,
        ERR_INDEX_PC   = 4'd3,
        ERR_SAME_PRE   = 4'd4,
        ERR_SAME_POST  = 4'd5
    } err_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_SWAP,
        CLS_HALF,
        CLS_COPROC,
        CLS_WORD_IMM,
        CLS_WORD_REG
    } xfer_cls_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] offset;
        logic              up;
        logic              wb;
        err_e              err;
    } dec_result_t;

endpackage

// File: rtl/ad_classify.sv
module ad_classify
    import abort_dec_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output xfer_cls_e         cls
);

    always_comb begin
        cls = CLS_NONE;
        if (instr[27:26] == 2'b01) begin
            cls = instr[BIT_REGOF] ? CLS_WORD_REG : CLS_WORD_IMM;
        end else if (instr[27:25] == 3'b000 && instr[7] && instr[4]) begin
            cls = (instr[6:5] == 2'b00) ? CLS_SWAP : CLS_HALF;
        end else if (instr[27:25] == 3'b110) begin
            cls = CLS_COPROC;
        end
    end

endmodule

// File: rtl/ad_shifter.sv
module ad_shifter #(
    parameter int W     = 32,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     value,
    input  logic [1:0]       kind,
    input  logic [AMT_W-1:0] amount,
    input  logic             carry,
    output logic [W-1:0]     result
);

    logic [2*W-1:0] doubled;
    logic           zero_amt;

    assign zero_amt = (amount == '0);
    assign doubled  = {value, value} >> amount;

    always_comb begin
        unique case (kind)
            2'b00: result = value << amount;
            2'b01: result = zero_amt ? '0 : (value >> amount);
            2'b10: result = zero_amt ? {W{value[W-1]}}
                                     : W'($signed(value) >>> amount);
            default: result = zero_amt ? {carry, value[W-1:1]}
                                       : doubled[W-1:0];
        endcase
    end

endmodule

// File: rtl/ad_check.sv
module ad_check
    import abort_dec_pkg::*;
(
    input  xfer_cls_e         cls,
    input  logic [WORD_W-1:0] instr,
    input  logic              wb_eff,
    output err_e              err
);

    logic [REG_W-1:0] base_r;
    logic [REG_W-1:0] index_r;
    logic             pre;
    logic             base_pc;
    logic             index_pc;
    logic             same_reg;
    err_e             same_code;

    assign base_r    = instr[19:16];
    assign index_r   = instr[3:0];
    assign pre       = instr[BIT_PRE];
    assign base_pc   = (base_r == {REG_W{1'b1}});
    assign index_pc  = (index_r == {REG_W{1'b1}});
    assign same_reg  = (base_r == index_r);
    assign same_code = pre ? ERR_SAME_PRE : ERR_SAME_POST;

    always_comb begin
        err = ERR_NONE;
        unique case (cls)
            CLS_NONE: err = ERR_UNEXPECTED;
            CLS_SWAP: begin
                if (!pre || instr[BIT_WB]) err = ERR_UNEXPECTED;
                else if (base_pc)          err = ERR_BASE_PC;
            end
            CLS_WORD_REG: begin
                if (instr[4])                 err = ERR_UNEXPECTED;
                else if (index_pc)            err = ERR_INDEX_PC;
                else if (same_reg && wb_eff)  err = same_code;
            end
            CLS_HALF: begin
                if (!instr[BIT_HIMM]) begin
                    if (index_pc)                err = ERR_INDEX_PC;
                    else if (same_reg && wb_eff) err = same_code;
                end
            end
            default: err = ERR_NONE;
        endcase
    end

endmodule

// File: rtl/abort_offset_decoder.sv
module abort_offset_decoder
    import abort_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] index_val,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] offset,
    output logic              up,
    output logic              wb,
    output logic [ERR_W-1:0]  err
);

    xfer_cls_e         cls;
    err_e              err_c;
    logic              wb_eff;
    logic              force_wb;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] off_c;
    dec_result_t       res_d;
    dec_result_t       res_q;

    ad_classify i_classify (
        .instr (instr),
        .cls   (cls)
    );

    ad_shifter #(.W(WORD_W), .AMT_W(AMT_W)) i_shifter (
        .value  (index_val),
        .kind   (instr[6:5]),
        .amount (instr[11:7]),
        .carry  (carry_in),
        .result (shifted)
    );

    // Post-indexed single transfers always write back
    assign force_wb = (cls == CLS_HALF) || (cls == CLS_WORD_IMM) || (cls == CLS_WORD_REG);
    assign wb_eff   = instr[BIT_WB] | (force_wb & ~instr[BIT_PRE]);

    ad_check i_check (
        .cls    (cls),
        .instr  (instr),
        .wb_eff (wb_eff),
        .err    (err_c)
    );

    always_comb begin
        off_c = '0;
        unique case (cls)
            CLS_HALF:     off_c = instr[BIT_HIMM] ? WORD_W'({instr[11:8], instr[3:0]}) : index_val;
            CLS_COPROC:   off_c = WORD_W'({instr[7:0], 2'b00});
            CLS_WORD_IMM: off_c = WORD_W'(instr[11:0]);
            CLS_WORD_REG: off_c = shifted;
            default:      off_c = '0;
        endcase
    end

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.offset = off_c;
            res_d.up     = instr[BIT_UP];
            res_d.wb     = wb_eff;
            res_d.err    = err_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign offset    = res_q.offset;
    assign up        = res_q.up;
    assign wb        = res_q.wb;
    assign err       = res_q.err;

endmodule

// File: rtl/abort_offset_decoder_chk.sv
module abort_offset_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        out_valid,
    input logic [31:0] offset,
    input logic        up,
    input logic        wb,
    input logic [3:0]  err
);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(offset) && $stable(err) && $stable(wb) && $stable(up));

    assert_err_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> err <= 4'd5);

    assert_wb_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && err == 4'd0 && $past(instr[27:26]) == 2'b01 && !$past(instr[24]) |-> wb);

    assert_swap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && err == 4'd0 && $past(instr[27:25]) == 3'b000 &&
        $past(instr[7:4]) == 4'b1001 |-> offset == 32'd0);

    assert_coproc_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(instr[27:25]) == 3'b110 |-> offset == {22'd0, $past(instr[7:0]), 2'b00});

    assert_up_copy_R14: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> up == $past(instr[23]));

endmodule

bind abort_offset_decoder abort_offset_decoder_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .offset    (offset),
    .up        (up),
    .wb        (wb),
    .err       (err)
);

// File: tb/test_abort_offset_decoder.sv
`timescale 1ns/1ps
module test_abort_offset_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] index_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] offset;
    logic        up;
    logic        wb;
    logic [3:0]  err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    abort_offset_decoder i_abort_offset_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .index_val (index_val),
        .carry_in  (carry_in),
        .out_valid (out_valid),
        .offset    (offset),
        .up        (up),
        .wb        (wb),
        .err       (err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive one strobe on a falling edge; results are sampled on the next falling edge.
    task automatic decode(input logic [31:0] ins, input logic [31:0] idx, input logic c);
        @(negedge clk);
        instr     = ins;
        index_val = idx;
        carry_in  = c;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic [31:0] e_off, input logic e_up,
                              input logic e_wb, input logic [3:0] e_err);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " err"}, {28'd0, err}, {28'd0, e_err});
        if (e_err == 4'd0) begin
            check({tag, " offset"}, offset, e_off);
            check({tag, " up"}, {31'd0, up}, {31'd0, e_up});
            check({tag, " wb"}, {31'd0, wb}, {31'd0, e_wb});
        end
    endtask

    task automatic t_reset;
        check("R2 valid", {31'd0, out_valid}, 32'd0);
        check("R2 offset", offset, 32'd0);
        check("R2 flags", {29'd0, up, wb, 1'b0}, 32'd0);
        check("R2 err", {28'd0, err}, 32'd0);
    endtask

    task automatic t_word_imm;
        decode(32'hE591_2ABC, 32'h0, 1'b0);
        expect_res("R8 pre up", 32'h0000_0ABC, 1'b1, 1'b0, 4'd0);
        decode(32'hE411_2004, 32'h0, 1'b0);
        expect_res("R4 R8 post down", 32'h0000_0004, 1'b0, 1'b1, 4'd0);
    endtask

    task automatic t_hold;
        decode(32'hE591_2ABC, 32'h0, 1'b0);
        @(negedge clk);
        check("R1 no strobe valid", {31'd0, out_valid}, 32'd0);
        check("R1 hold offset", offset, 32'h0000_0ABC);
        check("R1 hold err", {28'd0, err}, 32'd0);
    endtask

    task automatic t_shifts;
        decode(32'hE783_0185, 32'h0000_1234, 1'b0);
        expect_res("R12 lsl3", 32'h0000_91A0, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0005, 32'hCAFE_F00D, 1'b1);
        expect_res("R13 lsl0", 32'hCAFE_F00D, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0225, 32'h8000_00F0, 1'b0);
        expect_res("R12 lsr4", 32'h0800_000F, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0025, 32'hFFFF_FFFF, 1'b0);
        expect_res("R13 lsr0", 32'h0, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0245, 32'h8000_0000, 1'b0);
        expect_res("R12 asr4", 32'hF800_0000, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0045, 32'h8000_0000, 1'b0);
        expect_res("R13 asr0 neg", 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0045, 32'h7FFF_FFFF, 1'b0);
        expect_res("R13 asr0 pos", 32'h0, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0465, 32'h1234_5678, 1'b0);
        expect_res("R12 ror8", 32'h7812_3456, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0065, 32'h0000_0003, 1'b1);
        expect_res("R13 rrx c1", 32'h8000_0001, 1'b1, 1'b0, 4'd0);
        decode(32'hE783_0065, 32'h0000_0003, 1'b0);
        expect_res("R13 rrx c0", 32'h0000_0001, 1'b1, 1'b0, 4'd0);
    endtask

    task automatic t_word_reg_errors;
        decode(32'hE783_0015, 32'h0, 1'b0);
        expect_res("R11 bit4", 32'h0, 1'b0, 1'b0, 4'd1);
        decode(32'hE783_000F, 32'h0, 1'b0);
        expect_res("R9 word index pc", 32'h0, 1'b0, 1'b0, 4'd3);
        decode(32'hE7A3_0003, 32'h0, 1'b0);
        expect_res("R10 same pre", 32'h0, 1'b0, 1'b0, 4'd4);
        decode(32'hE683_0003, 32'h0, 1'b0);
        expect_res("R10 same post forced", 32'h0, 1'b0, 1'b0, 4'd5);
        decode(32'hE783_0003, 32'h0000_0010, 1'b0);
        expect_res("R10 same no wb", 32'h0000_0010, 1'b1, 1'b0, 4'd0);
        decode(32'hE7AF_000F, 32'h0, 1'b0);
        expect_res("R9 priority over R10", 32'h0, 1'b0, 1'b0, 4'd3);
    endtask

    task automatic t_half;
        decode(32'hE1D1_2AB5, 32'h0, 1'b0);
        expect_res("R6 half imm", 32'h0000_00A5, 1'b1, 1'b0, 4'd0);
        decode(32'hE051_2AB5, 32'h0, 1'b0);
        expect_res("R4 R6 half imm post", 32'h0000_00A5, 1'b0, 1'b1, 4'd0);
        decode(32'hE191_20B4, 32'h0000_DEAD, 1'b0);
        expect_res("R6 half reg", 32'h0000_DEAD, 1'b1, 1'b0, 4'd0);
        decode(32'hE191_20BF, 32'h0, 1'b0);
        expect_res("R9 half index pc", 32'h0, 1'b0, 1'b0, 4'd3);
        decode(32'hE094_20B4, 32'h0, 1'b0);
        expect_res("R10 half same post", 32'h0, 1'b0, 1'b0, 4'd5);
    endtask

    task automatic t_swap;
        decode(32'hE101_2093, 32'h1234_5678, 1'b0);
        expect_res("R5 swap ok", 32'h0, 1'b0, 1'b0, 4'd0);
        decode(32'hE10F_2093, 32'h0, 1'b0);
        expect_res("R5 swap base pc", 32'h0, 1'b0, 1'b0, 4'd2);
        decode(32'hE001_2093, 32'h0, 1'b0);
        expect_res("R5 swap post", 32'h0, 1'b0, 1'b0, 4'd1);
        decode(32'hE12F_2093, 32'h0, 1'b0);
        expect_res("R5 swap wb priority", 32'h0, 1'b0, 1'b0, 4'd1);
    endtask

    task automatic t_coproc;
        decode(32'hEDA2_153F, 32'h0, 1'b0);
        expect_res("R7 R14 coproc pre", 32'h0000_00FC, 1'b1, 1'b1, 4'd0);
        decode(32'hEC12_153F, 32'h0, 1'b0);
        expect_res("R4 R7 coproc post no force", 32'h0000_00FC, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_unknown;
        decode(32'hE081_0002, 32'h0, 1'b0);
        expect_res("R3 data op", 32'h0, 1'b0, 1'b0, 4'd1);
        decode(32'hEA00_0010, 32'h0, 1'b0);
        expect_res("R3 branch", 32'h0, 1'b0, 1'b0, 4'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word_imm();
        t_hold();
        t_shifts();
        t_word_reg_errors();
        t_half();
        t_swap();
        t_coproc();
        t_unknown();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule